// File: doc/BRIEF.md
# DS3 Far-End Alarm Code Receive Validator

This block sits behind the far-end alarm and control (FEAC) pattern extractor of a DS3 receiver. Each time the extractor recovers a 6-bit code word it pulses a strobe. The block keeps a sliding history of the last ten received codes. When no code is currently held and at least eight of those ten codes agree, it accepts that code. It latches the code into a readable register and raises a valid flag.

Once a code is held, the block watches the history for three or more codes that differ from it. When that happens it drops the valid flag but keeps the latched value readable. After a drop, a new code can be accepted by the same agreement rule.

A small register port exposes two bytes. The first is the latched code. The second is a control/status byte with two event enables, two sticky event flags that a read clears, and the valid flag. A single interrupt line is the OR of each sticky flag gated by its enable.

Top module: `feac_rx_validator`

## Requirements
- R1: Reading address 0 returns the latched code in bits 6..1, with bits 7 and 0 always 0.
- R2: While no code is held, a code that fills at least 8 of the last 10 received slots is latched and the valid flag (status bit 4) becomes 1. The result is readable two clock edges after the strobe edge.
- R3: An acceptance sets the sticky accept flag (status bit 0). Status bit 1 is the read/write enable for that flag.
- R4: While a code is held, once 3 or more of the last 10 received codes differ from it, the valid flag becomes 0 and the sticky drop flag (status bit 2) becomes 1. Status bit 3 is the read/write enable for the drop flag.
- R5: The interrupt output equals (bit0 AND bit1) OR (bit2 AND bit3) of the status byte.
- R6: A read strobe at address 1 clears bits 0 and 2 at that edge. An event at the same edge still sets its flag.
- R7: Writes at address 1 change only bits 1 and 3. Bits 7..5 read 0. Writes at address 0 have no effect.
- R8: A drop leaves the latched code unchanged. A later acceptance by the rule of R2 replaces it.
- R9: After reset, both bytes read 0 and the interrupt is low.
- R10: The history advances only on the strobe. Fewer than 8 agreeing codes never cause an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codeStb | input | 1 | One-cycle strobe: a received code word is present |
| codeIn | input | 6 | Received code word |
| regAddr | input | 1 | Register select: 0 latched code, 1 control/status |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (clears sticky flags at address 1) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| irqOut | output | 1 | Interrupt request |

## Verification
The strobe edge loads the history. Acceptance or drop registers at the next edge. An acceptance chained behind a drop registers one edge after that. Enable writes and read-clears act at the edge on which they are sampled, and the interrupt follows the status registers with no delay. The bench therefore pulses each code for one cycle, then idles two more cycles and samples at the falling edge. It reads the status byte without the read strobe, so sampling does not disturb the sticky flags. One directed case places the read strobe exactly on the event edge.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic latchCand;
  } dpCtrl_t;

  typedef enum logic {
    ADDR_CODE = 1'b0,
    ADDR_STAT = 1'b1
  } regAddr_e;

  localparam int BIT_VAL_ST  = 0;
  localparam int BIT_VAL_EN  = 1;
  localparam int BIT_REM_ST  = 2;
  localparam int BIT_REM_EN  = 3;
  localparam int BIT_FLAG    = 4;

endpackage

// File: rtl/feac_rx_dp.sv
module feac_rx_dp
  import feac_rx_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int DEPTH     = 10,
  parameter int VALID_MIN = 8,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctrlIn,
  input  logic [CODE_W-1:0] codeIn,
  output logic [CODE_W-1:0] latchedCode,
  output logic              candHit,
  output logic [CNT_W-1:0]  missCnt
);

  logic [DEPTH-1:0][CODE_W-1:0] hist;
  logic [DEPTH-1:0]             filled;
  logic [DEPTH-1:0]             slotHit;
  logic [CODE_W-1:0]            candCode;

  // history shift register, newest entry at index 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      filled <= '0;
    end else if (ctrlIn.shiftEn) begin
      hist   <= {hist[DEPTH-2:0], codeIn};
      filled <= {filled[DEPTH-2:0], 1'b1};
    end
  end

  // per-slot agreement count
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CNT_W-1:0] agree;
    always_comb begin
      agree = '0;
      for (int j = 0; j < DEPTH; j++)
        if (filled[j] && hist[j] == hist[i]) agree = agree + CNT_W'(1);
    end
    assign slotHit[i] = filled[i] && (agree >= CNT_W'(VALID_MIN));
  end

  always_comb begin
    candCode = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (slotHit[i]) candCode = hist[i];
  end
  assign candHit = |slotHit;

  // disagreement count against the held code
  always_comb begin
    missCnt = '0;
    for (int j = 0; j < DEPTH; j++)
      if (filled[j] && hist[j] != latchedCode) missCnt = missCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                latchedCode <= '0;
    else if (ctrlIn.latchCand) latchedCode <= candCode;
  end

  // R10: history frozen between strobes
  p_hist_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlIn.shiftEn |=> $stable(hist));

  // R8: latched code moves only on an acceptance
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlIn.latchCand |=> $stable(latchedCode));

endmodule

// File: rtl/feac_rx_ctrl.sv
module feac_rx_ctrl
  import feac_rx_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int REMOVE_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             codeStb,
  input  logic             candHit,
  input  logic [CNT_W-1:0] missCnt,
  input  logic             regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regWdata,
  output dpCtrl_t          dpCtrl,
  output logic [7:0]       statusByte,
  output logic             irqOut
);

  logic validFlag, validEn, removeEn, validSt, removeSt;
  logic validateEv, removeEv, statWr, statRd;

  assign validateEv = !validFlag && candHit;
  assign removeEv   = validFlag && (missCnt >= CNT_W'(REMOVE_MIN));
  assign statWr     = regWr && (regAddr == ADDR_STAT);
  assign statRd     = regRd && (regAddr == ADDR_STAT);

  assign dpCtrl.shiftEn   = codeStb;
  assign dpCtrl.latchCand = validateEv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validFlag <= 1'b0;
      validSt   <= 1'b0;
      removeSt  <= 1'b0;
      validEn   <= 1'b0;
      removeEn  <= 1'b0;
    end else begin
      if (validateEv)    validFlag <= 1'b1;
      else if (removeEv) validFlag <= 1'b0;
      validSt  <= (validSt && !statRd) || validateEv;
      removeSt <= (removeSt && !statRd) || removeEv;
      if (statWr) begin
        validEn  <= regWdata[BIT_VAL_EN];
        removeEn <= regWdata[BIT_REM_EN];
      end
    end
  end

  always_comb begin
    statusByte             = '0;
    statusByte[BIT_VAL_ST] = validSt;
    statusByte[BIT_VAL_EN] = validEn;
    statusByte[BIT_REM_ST] = removeSt;
    statusByte[BIT_REM_EN] = removeEn;
    statusByte[BIT_FLAG]   = validFlag;
  end

  assign irqOut = (validSt && validEn) || (removeSt && removeEn);

  // R2/R3: acceptance raises flag and sticky bit
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    validateEv |=> (validFlag && validSt));

  // R4: drop lowers flag and raises sticky bit
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    removeEv |=> (!validFlag && removeSt));

  // R6: read clears accept flag unless a new acceptance arrives
  p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (statRd && !validateEv) |=> !validSt);

  // R5: interrupt cannot appear without an event or enable write
  p_irq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irqOut && !validateEv && !removeEv && !statWr) |=> !irqOut);

  // R4: acceptance and drop never coincide
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(validateEv && removeEv));

endmodule

// File: rtl/feac_rx_validator.sv
module feac_rx_validator
  import feac_rx_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int DEPTH      = 10,
  parameter int VALID_MIN  = 8,
  parameter int REMOVE_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              codeStb,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              irqOut
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  dpCtrl_t           dpCtrl;
  logic [CODE_W-1:0] latchedCode;
  logic              candHit;
  logic [CNT_W-1:0]  missCnt;
  logic [7:0]        statusByte;

  feac_rx_dp #(
    .CODE_W(CODE_W), .DEPTH(DEPTH), .VALID_MIN(VALID_MIN), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrlIn(dpCtrl), .codeIn(codeIn),
    .latchedCode(latchedCode), .candHit(candHit), .missCnt(missCnt)
  );

  feac_rx_ctrl #(
    .CNT_W(CNT_W), .REMOVE_MIN(REMOVE_MIN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .codeStb(codeStb), .candHit(candHit),
    .missCnt(missCnt), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .dpCtrl(dpCtrl), .statusByte(statusByte),
    .irqOut(irqOut)
  );

  always_comb begin
    if (regAddr == ADDR_STAT) regRdata = statusByte;
    else                      regRdata = 8'({latchedCode, 1'b0});
  end

  // R1: pad bits of the code byte stay zero
  p_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_CODE) |-> (regRdata[7] == 1'b0 && regRdata[0] == 1'b0));

endmodule

// File: tb/feac_rx_validator_tb.sv
module feac_rx_validator_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       codeStb;
  logic [5:0] codeIn;
  logic       regAddr, regWr, regRd;
  logic [7:0] regWdata, regRdata;
  logic       irqOut;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  feac_rx_validator u_dut (
    .clk(clk), .rst_n(rst_n), .codeStb(codeStb), .codeIn(codeIn),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  // reference model
  logic [5:0] mHist [10];
  bit         mFill [10];
  bit         mVal, mVst, mRst, mVen, mRen;
  logic [5:0] mCode;

  function automatic int cntOf(logic [5:0] c);
    int n = 0;
    for (int i = 0; i < 10; i++) if (mFill[i] && mHist[i] == c) n++;
    return n;
  endfunction

  function automatic int missOf(logic [5:0] c);
    int n = 0;
    for (int i = 0; i < 10; i++) if (mFill[i] && mHist[i] != c) n++;
    return n;
  endfunction

  function automatic logic [7:0] expStat();
    return {3'b000, mVal, mRen, mRst, mVen, mVst};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 10; i++) begin mHist[i] = '0; mFill[i] = 0; end
    mVal = 0; mVst = 0; mRst = 0; mVen = 0; mRen = 0; mCode = '0;
  endtask

  task automatic modelShift(logic [5:0] c);
    for (int i = 9; i > 0; i--) begin mHist[i] = mHist[i-1]; mFill[i] = mFill[i-1]; end
    mHist[0] = c; mFill[0] = 1;
    if (mVal && missOf(mCode) >= 3) begin mVal = 0; mRst = 1; end
    if (!mVal) begin
      for (int i = 0; i < 10; i++) begin
        if (!mVal && mFill[i] && cntOf(mHist[i]) >= 8) begin
          mVal = 1; mVst = 1; mCode = mHist[i];
        end
      end
    end
  endtask

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // non-destructive peek of both bytes and the interrupt
  task automatic checkAll(string tag);
    regAddr = 1'b0; #1;
    cmp(tag, "code byte", regRdata, {1'b0, mCode, 1'b0});
    regAddr = 1'b1; #1;
    cmp(tag, "status byte", regRdata, expStat());
    cmp(tag, "irq", {7'd0, irqOut}, {7'd0, (mVst & mVen) | (mRst & mRen)});
  endtask

  task automatic sendCode(logic [5:0] c);
    @(negedge clk); codeStb = 1'b1; codeIn = c;
    @(negedge clk); codeStb = 1'b0; codeIn = $urandom_range(0, 63);
    @(negedge clk);
    @(negedge clk);
    modelShift(c);
  endtask

  task automatic writeStat(logic [7:0] d);
    @(negedge clk); regAddr = 1'b1; regWr = 1'b1; regWdata = d;
    @(negedge clk); regWr = 1'b0;
    mVen = d[1]; mRen = d[3];
  endtask

  task automatic readClear();
    @(negedge clk); regAddr = 1'b1; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0;
    mVst = 0; mRst = 0;
  endtask

  initial begin
    #(150000 * 5);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; codeStb = 1'b0; codeIn = '0;
    regAddr = 1'b0; regWr = 1'b0; regRd = 1'b0; regWdata = '0;
    modelReset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkAll("R9 reset");

    // R10: seven agreeing codes never accept
    for (int i = 0; i < 7; i++) sendCode(6'h15);
    for (int i = 0; i < 3; i++) sendCode(6'h2A);
    checkAll("R10 seven of ten");
    cmp("R10", "flag low", {7'd0, mVal}, 8'd0);

    // R7: writes at address 0 ignored; only enables writable
    @(negedge clk); regAddr = 1'b0; regWr = 1'b1; regWdata = 8'hFF;
    @(negedge clk); regWr = 1'b0;
    checkAll("R7 addr0 write");
    writeStat(8'hFF);
    checkAll("R7 enable write");
    writeStat(8'h00);

    // R2/R3/R1: accept 0x15, enable off then on
    for (int i = 0; i < 8; i++) sendCode(6'h15);
    checkAll("R2 accept");
    regAddr = 1'b0; #1;
    cmp("R1", "code byte", regRdata, 8'h2A);
    cmp("R3", "irq masked", {7'd0, irqOut}, 8'd0);
    writeStat(8'h02);
    checkAll("R5 accept irq");
    cmp("R5", "irq on", {7'd0, irqOut}, 8'd1);
    readClear();
    checkAll("R6 read clear");

    // R4/R8: three differing codes drop, code retained
    writeStat(8'h0A);
    for (int i = 0; i < 3; i++) sendCode(6'h07);
    checkAll("R4 drop");
    regAddr = 1'b0; #1;
    cmp("R8", "code kept", regRdata, 8'h2A);
    regAddr = 1'b1; #1;
    cmp("R4", "flag low", regRdata & 8'h14, 8'h04);

    // R8: new code accepted afterwards
    for (int i = 0; i < 8; i++) sendCode(6'h3C);
    checkAll("R8 reaccept");
    regAddr = 1'b0; #1;
    cmp("R8", "new code", regRdata, 8'h78);
    readClear();

    // R6: read strobe on the very edge of a drop event
    sendCode(6'h01); sendCode(6'h01);
    @(negedge clk); codeStb = 1'b1; codeIn = 6'h01;
    @(negedge clk); codeStb = 1'b0; regAddr = 1'b1; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0;
    @(negedge clk);
    mVst = 0; mRst = 0;
    modelShift(6'h01);
    checkAll("R6 event beats clear");
    cmp("R6", "drop kept", regRdata & 8'h04, 8'h04);

    // random phase
    begin
      logic [5:0] fav = 6'h11;
      for (int n = 0; n < 600; n++) begin
        int op = $urandom_range(0, 99);
        if (n % 40 == 0) fav = 6'($urandom_range(0, 63));
        if (op < 8)       writeStat(8'($urandom_range(0, 255)));
        else if (op < 16) readClear();
        else if ($urandom_range(0, 3) != 0) sendCode(fav);
        else sendCode(6'($urandom_range(0, 63)));
        checkAll("R2 R4 R5 random");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule